// File: doc/BRIEF.md
# Grouped GPIO Interrupt Status Aggregator

This block folds the pending-interrupt state of a large bank of GPIO pins into a compact summary that software can scan quickly. Each pin supplies two flags, an interrupt flag and a wake flag, and a pin is pending when either flag is set. Pins are taken in groups of four consecutive pins, and each group gives one summary bit. With the default 184 pins there are 46 summary bits. Pin detection itself happens elsewhere: this block only collects what the pins report.

Software reads the summary as two 32-bit words through a small request/response register port. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A read returns one response on `rsp_valid`/`rsp_rdata`, and that response is held until `rsp_ready` is high. While a response waits, `req_ready` stays low, so a stalled consumer stops new requests. Writes return no response.

A single upstream line, `irq_out`, tells the host that something is pending. The line fires once and then waits. It is re-armed only when software writes the end-of-interrupt bit in the control word. It then fires again if any summary bit is still set.

Top module: `grp_irq_aggregator`

## Requirements
- R1: Summary bit n is set one clock after any of pins 4n..4n+3 has its interrupt flag set. The low summary word, at byte address 0x00, carries summary bits 0..31 in bit positions 0..31.
- R2: The high summary word, at byte address 0x04, carries summary bits 32..45 in bit positions 0..13. Its bit positions 14..31 always read 0.
- R3: When the line is armed and any summary bit is set, `irq_out` is high for exactly one clock and the line becomes disarmed. It stays low after that even if bits remain set.
- R4: Writing 1 to bit 0 of the control word, at byte address 0x08, re-arms the line (end-of-interrupt). If any summary bit is set, `irq_out` pulses in the cycle after the accepting edge. If nothing is pending, there is no pulse until something becomes pending.
- R5: A read of the control word always returns 0. A write to the control word with bit 0 clear does not re-arm the line.
- R6: Writes to the two summary words are ignored. They change neither the summary contents nor the interrupt line.
- R7: A read of any other word address (0x0C and above) returns 0. The two low address bits are ignored.
- R8: A read accepted on a clock edge returns its response from that edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds steady and `req_ready` is low.
- R9: During and right after reset, `irq_out` and `rsp_valid` are low, the summary is all zero and the line is armed. A pin pending after reset therefore fires without any end-of-interrupt write.
- R10: A pin whose wake flag alone is set counts as pending, exactly as if its interrupt flag were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_irq | input | NUM_PINS | Per-pin interrupt flags |
| pin_wake | input | NUM_PINS | Per-pin wake flags |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the read response |
| rsp_rdata | output | 32 | Read response data |
| irq_out | output | 1 | Upstream interrupt pulse |

## Verification
The bench walks the group boundaries: the first and last pin of a group, the last group of the low word, the first group of the high word, and the final group. A design that shifted groups by one pin, or split the words at the wrong bit, would return a bit in the wrong place. It counts upstream pulses while pins stay pending. A line that was level-driven, or that re-armed by itself, would show extra pulses. It also checks that a control write with bit 0 clear, a write to a summary word, and a control read never re-arm the line or return data. A read is then stalled with `rsp_ready` low. A port that dropped or changed the response, or took a new request during the stall, would break the hold and blocking checks.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CTRL_EOI_BIT = 0;

  // word indices (byte address / 4)
  localparam int unsigned WIDX_SUM_LO = 0;
  localparam int unsigned WIDX_SUM_HI = 1;
  localparam int unsigned WIDX_CTRL   = 2;

  typedef enum logic [1:0] {
    SEL_SUM_LO = 2'd0,
    SEL_SUM_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/grp_irq_summary.sv
module grp_irq_summary #(
  parameter int unsigned NUM_PINS      = 184,
  parameter int unsigned PINS_PER_GRP  = 4,
  parameter int unsigned NUM_GRPS      = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_irq,
  input  logic [NUM_PINS-1:0] pin_wake,
  output logic [NUM_GRPS-1:0] summary_q
);

  localparam int unsigned PAD_PINS = NUM_GRPS * PINS_PER_GRP;

  logic [PAD_PINS-1:0] pend_pad;
  logic [NUM_GRPS-1:0] grp_hit;

  // R10: either flag makes a pin pending; pins past NUM_PINS read as idle
  assign pend_pad = PAD_PINS'(pin_irq | pin_wake);

  // R1: one OR reduction per group of consecutive pins
  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    assign grp_hit[g] = |pend_pad[g*PINS_PER_GRP +: PINS_PER_GRP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary_q <= '0;
    else        summary_q <= grp_hit;
  end

endmodule

// File: rtl/grp_irq_rearm.sv
module grp_irq_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pending,
  input  logic eoi_req,
  output logic irq_o
);

  logic armed_q;
  logic fire;

  // R3: fire once when armed and something is pending
  assign fire = armed_q && any_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;               // R9: armed out of reset
      irq_o   <= 1'b0;
    end else begin
      irq_o <= fire;
      if (eoi_req)   armed_q <= 1'b1; // R4: end-of-interrupt re-arms
      else if (fire) armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/grp_irq_regif.sv
module grp_irq_regif
  import grp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_GRPS = 46
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_rdata,
  input  logic [NUM_GRPS-1:0] summary,
  output logic                eoi_req
);

  localparam int unsigned SUM_W  = 2 * WORD_W;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [SUM_W-1:0]  sum_ext;
  logic [WORD_W-1:0] rd_word;
  logic              accept;
  reg_sel_e          sel;
  logic              unused_bits;

  assign widx    = req_addr[ADDR_W-1:2];   // R7: byte lanes ignored
  assign sum_ext = SUM_W'(summary);         // R2: bits above the groups are zero
  assign unused_bits = ^{req_addr[1:0], req_wdata};

  always_comb begin
    if (widx == WIDX_W'(WIDX_SUM_LO))      sel = SEL_SUM_LO;
    else if (widx == WIDX_W'(WIDX_SUM_HI)) sel = SEL_SUM_HI;
    else if (widx == WIDX_W'(WIDX_CTRL))   sel = SEL_CTRL;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_SUM_LO: rd_word = sum_ext[WORD_W-1:0];
      SEL_SUM_HI: rd_word = sum_ext[SUM_W-1:WORD_W];
      default:    rd_word = '0;               // R5, R7
    endcase
  end

  // R8: a waiting response blocks new requests
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  // R4, R5, R6: only a control write with the EOI bit set has an effect
  assign eoi_req = accept && req_write && (sel == SEL_CTRL) &&
                   req_wdata[CTRL_EOI_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/grp_irq_aggregator.sv
module grp_irq_aggregator
  import grp_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 184,
  parameter int unsigned PINS_PER_GRP = 4,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_irq,
  input  logic [NUM_PINS-1:0] pin_wake,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  output logic                irq_out
);

  localparam int unsigned NUM_GRPS = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;

  logic [NUM_GRPS-1:0] summary_q;
  logic                eoi_req;

  grp_irq_summary #(
    .NUM_PINS     (NUM_PINS),
    .PINS_PER_GRP (PINS_PER_GRP),
    .NUM_GRPS     (NUM_GRPS)
  ) u_summary (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_irq   (pin_irq),
    .pin_wake  (pin_wake),
    .summary_q (summary_q)
  );

  grp_irq_regif #(
    .ADDR_W   (ADDR_W),
    .NUM_GRPS (NUM_GRPS)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .summary   (summary_q),
    .eoi_req   (eoi_req)
  );

  grp_irq_rearm u_rearm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_pending (|summary_q),
    .eoi_req     (eoi_req),
    .irq_o       (irq_out)
  );

endmodule

// File: rtl/grp_irq_aggregator_chk.sv
module grp_irq_aggregator_chk #(
  parameter int unsigned NUM_PINS = 184,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_irq,
  input logic [NUM_PINS-1:0] pin_wake,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [31:0]         req_wdata,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic                irq_out
);

  logic eoi_acc;
  assign eoi_acc = req_valid && req_ready && req_write &&
                   (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(2)) && req_wdata[0];

  // R3
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !$past(eoi_acc) |=> !irq_out);

  // R1
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(pin_irq | pin_wake), 2));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!irq_out && !rsp_valid);
    end
  end

endmodule

bind grp_irq_aggregator grp_irq_aggregator_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_irq   (pin_irq),
  .pin_wake  (pin_wake),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq_out   (irq_out)
);

// File: tb/grp_irq_aggregator_tb_top.sv
module grp_irq_aggregator_tb_top;

  localparam int NP = 184;
  localparam int AW = 8;
  localparam int NV = 8;

  // {pin[7:0], wake_only, expected lo, expected hi}
  localparam logic [72:0] VEC [NV] = '{
    {8'd0,   1'b0, 32'h0000_0001, 32'h0000_0000},
    {8'd3,   1'b0, 32'h0000_0001, 32'h0000_0000},
    {8'd4,   1'b0, 32'h0000_0002, 32'h0000_0000},
    {8'd127, 1'b0, 32'h8000_0000, 32'h0000_0000},
    {8'd128, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {8'd183, 1'b0, 32'h0000_0000, 32'h0000_2000},
    {8'd130, 1'b1, 32'h0000_0000, 32'h0000_0001},
    {8'd65,  1'b1, 32'h0001_0000, 32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_irq = '0;
  logic [NP-1:0] pin_wake = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic          irq_out;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  grp_irq_aggregator #(.NUM_PINS(NP), .PINS_PER_GRP(4), .ADDR_W(AW)) dut_i (
    .clk, .rst_n, .pin_irq, .pin_wake, .req_valid, .req_ready, .req_write,
    .req_addr, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .irq_out
  );

  always @(negedge clk) if (irq_out) irq_cnt <= irq_cnt + 1;

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    step();
    req_valid = 1'b0;
    d = rsp_rdata;
    step();
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int base;
    step(3);
    // R9: reset state
    check("R9 irq in reset", 32'(irq_out), 0);
    check("R9 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    step(2);
    check("R9 req_ready after reset", 32'(req_ready), 1);
    reg_read(8'h00, rd); check("R9 summary lo zero", rd, 0);
    reg_read(8'h04, rd); check("R9 summary hi zero", rd, 0);
    check("R9 no irq without pins", 32'(irq_cnt), 0);

    // R1, R2, R10: vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][64]) pin_wake[VEC[v][72:65]] = 1'b1;
      else            pin_irq[VEC[v][72:65]]  = 1'b1;
      step(2);
      reg_read(8'h00, rd); check("R1 R10 low word", rd, VEC[v][63:32]);
      reg_read(8'h04, rd); check("R2 R10 high word", rd, VEC[v][31:0]);
      pin_irq = '0; pin_wake = '0;
      step(2);
    end
    // R3: one pulse for the whole table, line stays disarmed
    check("R3 single pulse", 32'(irq_cnt), 1);

    // R4: EOI with nothing pending gives no pulse
    reg_write(8'h08, 32'h1);
    step(4);
    check("R4 eoi idle no pulse", 32'(irq_cnt), 1);
    pin_irq[10] = 1'b1;
    step(6);
    check("R4 armed fires on new pin", 32'(irq_cnt), 2);
    check("R3 no repeat while pending", 32'(irq_cnt), 2);
    // R5: control write with bit 0 clear
    reg_write(8'h08, 32'hFFFF_FFFE);
    step(4);
    check("R5 write zero eoi no rearm", 32'(irq_cnt), 2);
    // R6: writes to summary words ignored
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_write(8'h04, 32'hFFFF_FFFF);
    step(4);
    check("R6 status write no rearm", 32'(irq_cnt), 2);
    reg_read(8'h00, rd); check("R6 low word unchanged", rd, 32'h0000_0004);
    reg_read(8'h04, rd); check("R6 high word unchanged", rd, 0);
    // R4: EOI with pending pin re-fires on the next cycle
    base = irq_cnt;
    reg_write(8'h08, 32'h1);
    step();
    check("R4 refire after eoi", 32'(irq_cnt), 32'(base + 1));
    step(4);
    check("R4 only one refire", 32'(irq_cnt), 32'(base + 1));
    // R5, R7
    reg_read(8'h08, rd); check("R5 control reads zero", rd, 0);
    reg_read(8'h0C, rd); check("R7 unmapped 0x0C", rd, 0);
    reg_read(8'hF0, rd); check("R7 unmapped 0xF0", rd, 0);
    reg_read(8'h02, rd); check("R7 byte lanes ignored", rd, 32'h0000_0004);

    // R8: back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    step();
    req_valid = 1'b0;
    check("R8 rsp_valid raised", 32'(rsp_valid), 1);
    check("R8 req_ready low in stall", 32'(req_ready), 0);
    step(3);
    check("R8 rsp held", 32'(rsp_valid), 1);
    check("R8 data held", rsp_rdata, 32'h0000_0004);
    rsp_ready = 1'b1;
    step();
    check("R8 rsp released", 32'(rsp_valid), 0);

    // R9: mid-run reset re-arms the line
    pin_irq = '0; pin_irq[0] = 1'b1;
    rst_n = 1'b0;
    base = irq_cnt;
    step(2);
    check("R9 irq low in reset", 32'(irq_out), 0);
    rst_n = 1'b1;
    step(5);
    check("R9 armed after reset", 32'(irq_cnt), 32'(base + 1));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule